// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves a stream of bytes between a SCSI core and system memory on the SCSI core's behalf. Software programs a start count, a start address and a start page pointer, then writes a start command. The engine copies these into working registers and serves burst requests from the SCSI core. Each byte of a burst goes out as one request on a memory port that carries an address and a direction. The working count and address advance with every accepted byte, and the done flag rises when the count runs out.

Two addressing modes exist. In flat mode the address simply counts upward. In page-list mode the address is the OR of an in-page offset with a window of the page pointer. When the offset carries into the page-size bit, the offset returns to zero and the page pointer steps to the next 4 KB page. The page pointer is used directly as the page base; no descriptor list is fetched from memory. The engine also mirrors the SCSI core's interrupt line into a status bit.

Top module: `sgdma_engine`

## Requirements
- R1: After reset, the working count and working address read 0, the working page pointer reads 0xFFFFFFFC, status reads 0 and `mem_valid` is low.
- R2: Writing the command register with op code 3 (start, bits [1:0]) loads the working address from the start address, the working page pointer from the start page pointer, and the working count from the 24-bit start count. A start count of 0 loads 0x1000000.
- R3: A start command clears status bit 0 (done) and status bit 1 (SCSI interrupt).
- R4: In flat mode (command bit 3 = 0), a burst request of length L produces min(L, working count) byte beats. Each beat is issued at the current working address with `mem_write` equal to command bit 2. Each accepted beat raises the address by one and lowers the count by one.
- R5: In page-list mode (command bit 3 = 1), each beat is issued at working address OR (working page pointer AND 0x000FF000).
- R6: In page-list mode, a beat that brings the working address to a value with bit 12 set leaves the working address at 0 and adds 0x1000 to the working page pointer.
- R7: When the working count reaches zero it stays at zero and the done bit is set. Later burst requests are accepted but produce no beats.
- R8: A burst request whose `xfer_dir` differs from command bit 2 is accepted and discarded: no beats occur and no working register changes.
- R9: Status bit 1 follows `scsi_irq`. While the op code is start and the working count is zero, a high `scsi_irq` also sets done. Writing the status register (address 4) with a 1 in a bit position clears that bit.
- R10: While the op code is not start, `xfer_ready` and `mem_valid` stay low and the working registers keep their values for readback.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 command, 1 start count, 2 start address, 3 start page pointer, 4 status, 5 working count, 6 working address, 7 working page pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| scsi_irq | input | 1 | Interrupt level from the SCSI core |
| xfer_valid | input | 1 | SCSI core presents a burst request |
| xfer_ready | output | 1 | Engine takes the burst request |
| xfer_dir | input | 1 | Burst direction, 1 = toward memory |
| xfer_len | input | 16 | Burst length in bytes |
| mem_valid | output | 1 | Memory request valid, one byte per beat |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the request |
| mem_write | output | 1 | Request direction, 1 = write to memory |

## Verification
Page-list runs start a few bytes short of a page end. A design that wraps on the wrong bit, or forgets to step the page pointer, issues the wrong address there. Bursts longer than the remaining count check the clamp: a design without it runs past zero and wraps the count to a huge value. The bench also presents a request in the wrong direction, presents requests after the count is exhausted, and checks the zero-count start that must load 16M. A design that mishandles these shows extra beats or a count of zero. Random memory stalls, and the interrupt-driven done path with the op code idle and with it at start, cover the corners where a careless design drops a request mid-stall or sets done regardless of the command.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   localparam int REG_IW = 3;

   typedef enum logic [REG_IW-1:0] {
      RA_CMD   = 3'd0,
      RA_SCNT  = 3'd1,
      RA_SADDR = 3'd2,
      RA_SLIST = 3'd3,
      RA_STAT  = 3'd4,
      RA_WCNT  = 3'd5,
      RA_WADDR = 3'd6,
      RA_WLIST = 3'd7
   } reg_idx_e;

   localparam logic [1:0] OP_IDLE  = 2'd0;
   localparam logic [1:0] OP_START = 2'd3;

   localparam int CMD_W        = 4;
   localparam int CMD_DIR_BIT  = 2;
   localparam int CMD_LIST_BIT = 3;

   localparam int ST_DONE = 0;
   localparam int ST_SINT = 1;
   localparam int ST_W    = 2;

   typedef enum logic {SQ_IDLE, SQ_RUN} seq_state_e;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
   import sgdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_IW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              scsi_irq,
   input  logic [CW-1:0]     wcnt,
   input  logic [AW-1:0]     waddr,
   input  logic [AW-1:0]     wlist,
   input  logic              last_beat,
   output logic              start,
   output logic              active,
   output logic              cmd_dir,
   output logic              cmd_list,
   output logic [CW-1:0]     scnt_load,
   output logic [AW-1:0]     saddr,
   output logic [AW-1:0]     slist,
   output logic [ST_W-1:0]   status
);
   localparam int SCW = CW - 1;

   logic [CMD_W-1:0] cmd;
   logic [SCW-1:0]   scnt;
   logic             wr_cmd, wr_stat;

   assign wr_cmd  = reg_we && (reg_addr == RA_CMD);
   assign wr_stat = reg_we && (reg_addr == RA_STAT);
   assign start   = wr_cmd && (reg_wdata[1:0] == OP_START);
   assign active  = (cmd[1:0] == OP_START);
   assign cmd_dir  = cmd[CMD_DIR_BIT];
   assign cmd_list = cmd[CMD_LIST_BIT];
   assign scnt_load = (scnt == '0) ? (CW'(1) << SCW) : {1'b0, scnt};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd   <= '0;
         scnt  <= '0;
         saddr <= '0;
         slist <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_CMD:   cmd   <= reg_wdata[CMD_W-1:0];
            RA_SCNT:  scnt  <= reg_wdata[SCW-1:0];
            RA_SADDR: saddr <= reg_wdata[AW-1:0];
            RA_SLIST: slist <= reg_wdata[AW-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
      end else if (start) begin
         status <= '0;
      end else begin
         status[ST_SINT] <= scsi_irq && !(wr_stat && reg_wdata[ST_SINT]);
         if (last_beat || (scsi_irq && active && (wcnt == '0)))
            status[ST_DONE] <= 1'b1;
         else if (wr_stat && reg_wdata[ST_DONE])
            status[ST_DONE] <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CMD:   reg_rdata = 32'(cmd);
         RA_SCNT:  reg_rdata = 32'(scnt);
         RA_SADDR: reg_rdata = 32'(saddr);
         RA_SLIST: reg_rdata = 32'(slist);
         RA_STAT:  reg_rdata = 32'(status);
         RA_WCNT:  reg_rdata = 32'(wcnt);
         RA_WADDR: reg_rdata = 32'(waddr);
         RA_WLIST: reg_rdata = 32'(wlist);
         default:  reg_rdata = '0;
      endcase
   end

   // R3
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (status == '0));

   // R9
   sint_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !scsi_irq) |=> !status[ST_SINT]);
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker #(
   parameter int AW         = 32,
   parameter int CW         = 25,
   parameter int PAGE_SHIFT = 12,
   parameter int PG_BITS    = 8,
   parameter bit HAS_LIST   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          beat,
   input  logic          list_mode,
   input  logic [AW-1:0] saddr,
   input  logic [AW-1:0] slist,
   input  logic [CW-1:0] scnt_load,
   output logic [CW-1:0] wcnt,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] wlist,
   output logic [AW-1:0] mem_addr,
   output logic          last_beat
);
   localparam logic [AW-1:0] PAGE_STEP = AW'(1) << PAGE_SHIFT;
   localparam logic [AW-1:0] PG_MASK   = ((AW'(1) << PG_BITS) - AW'(1)) << PAGE_SHIFT;
   localparam logic [AW-1:0] WLIST_RST = ~AW'(3);

   if ((PAGE_SHIFT < 1) || (PAGE_SHIFT + PG_BITS > AW)) begin : g_bad_page
      $error("sgdma_walker: page window does not fit the address width");
   end

   logic          list_eff;
   logic [AW-1:0] addr_inc;

   if (HAS_LIST) begin : g_list
      assign list_eff = list_mode;
      assign mem_addr = list_mode ? (waddr | (wlist & PG_MASK)) : waddr;
   end else begin : g_flat
      assign list_eff = 1'b0;
      assign mem_addr = waddr;
   end

   assign addr_inc  = waddr + AW'(1);
   assign last_beat = beat && !start && (wcnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt  <= '0;
         waddr <= '0;
         wlist <= WLIST_RST;
      end else if (start) begin
         wcnt  <= scnt_load;
         waddr <= saddr;
         wlist <= slist;
      end else if (beat && (wcnt != '0)) begin
         wcnt <= wcnt - CW'(1);
         if (list_eff && addr_inc[PAGE_SHIFT]) begin
            waddr <= '0;
            wlist <= wlist + PAGE_STEP;
         end else begin
            waddr <= addr_inc;
         end
      end
   end

   // R6
   page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && list_eff && !start) |=> !waddr[PAGE_SHIFT]);

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> (wcnt != '0));
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
   import sgdma_pkg::*;
#(
   parameter int CW    = 25,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             dir_match,
   input  logic [CW-1:0]    wcnt,
   input  logic             xfer_valid,
   input  logic [LEN_W-1:0] xfer_len,
   output logic             xfer_ready,
   input  logic             mem_ready,
   output logic             mem_valid,
   output logic             beat
);
   if (LEN_W > CW) begin : g_bad_len
      $error("sgdma_seq: burst length wider than the count");
   end

   seq_state_e    state;
   logic [CW-1:0] rem, len_ext, take;
   logic          accept;

   assign len_ext    = CW'(xfer_len);
   assign take       = (len_ext < wcnt) ? len_ext : wcnt;
   assign xfer_ready = (state == SQ_IDLE) && active;
   assign accept     = xfer_valid && xfer_ready;
   assign mem_valid  = (state == SQ_RUN) && active;
   assign beat       = mem_valid && mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         rem   <= '0;
      end else if (start || !active) begin
         state <= SQ_IDLE;
      end else if (state == SQ_IDLE) begin
         if (accept && dir_match && (take != '0)) begin
            rem   <= take;
            state <= SQ_RUN;
         end
      end else if (beat) begin
         rem <= rem - CW'(1);
         if (rem == CW'(1)) state <= SQ_IDLE;
      end
   end

   // R8
   drop_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !dir_match) |=> !mem_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!mem_valid && !xfer_ready));
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
   import sgdma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 25,
   parameter int LEN_W      = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int PG_BITS    = 8,
   parameter bit HAS_LIST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_IW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              scsi_irq,
   input  logic              xfer_valid,
   output logic              xfer_ready,
   input  logic              xfer_dir,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_write
);
   if ((AW > 32) || (CW > 32) || (CW < 2)) begin : g_bad_width
      $error("sgdma_engine: widths must fit the 32-bit register port");
   end

   logic              start, active, cmd_dir, cmd_list, beat, last_beat;
   logic [CW-1:0]     scnt_load, wcnt;
   logic [AW-1:0]     saddr, slist, waddr, wlist;
   logic [ST_W-1:0]   status;

   assign mem_write = cmd_dir;

   sgdma_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scsi_irq(scsi_irq),
      .wcnt(wcnt), .waddr(waddr), .wlist(wlist), .last_beat(last_beat),
      .start(start), .active(active), .cmd_dir(cmd_dir), .cmd_list(cmd_list),
      .scnt_load(scnt_load), .saddr(saddr), .slist(slist), .status(status)
   );

   sgdma_walker #(.AW(AW), .CW(CW), .PAGE_SHIFT(PAGE_SHIFT), .PG_BITS(PG_BITS),
                  .HAS_LIST(HAS_LIST)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .beat(beat), .list_mode(cmd_list),
      .saddr(saddr), .slist(slist), .scnt_load(scnt_load), .wcnt(wcnt),
      .waddr(waddr), .wlist(wlist), .mem_addr(mem_addr), .last_beat(last_beat)
   );

   sgdma_seq #(.CW(CW), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active),
      .dir_match(xfer_dir == cmd_dir), .wcnt(wcnt), .xfer_valid(xfer_valid),
      .xfer_len(xfer_len), .xfer_ready(xfer_ready), .mem_ready(mem_ready),
      .mem_valid(mem_valid), .beat(beat)
   );

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (!mem_valid || $stable(mem_addr)));

   // R7
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !start && (wcnt == CW'(1))) |=> status[ST_DONE]);
endmodule

// File: tb/sgdma_engine_bench.sv
module sgdma_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        scsi_irq = 1'b0;
   logic        xfer_valid = 1'b0;
   logic        xfer_ready;
   logic        xfer_dir = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_addr;
   logic        mem_write;

   always #2.5 clk = ~clk;

   sgdma_engine u_sgdma_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scsi_irq(scsi_irq),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
      .xfer_len(xfer_len), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_write(mem_write)
   );

   int total = 0, fails = 0, beats = 0;
   bit finished = 0, stall_on = 0;
   logic [31:0] m_wac, m_wmac, m_wbc;
   bit m_list, m_dir, m_done;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr();
      return m_list ? (m_wac | (m_wmac & 32'h000F_F000)) : m_wac;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // memory side: random ready, address check per beat, stall hold check
   initial begin
      logic        prev_stall = 1'b0;
      logic [31:0] prev_addr = '0;
      forever begin
         @(negedge clk);
         mem_ready = stall_on ? (($urandom % 4) != 0) : 1'b1;
         #1;
         if (prev_stall) begin
            chk("R11 valid held", {31'b0, mem_valid}, 32'd1);
            chk("R11 addr held", mem_addr, prev_addr);
         end
         prev_stall = mem_valid && !mem_ready && rst_n;
         prev_addr  = mem_addr;
         if (rst_n && mem_valid && mem_ready) begin
            chk(m_list ? "R5 beat addr" : "R4 beat addr", mem_addr, exp_addr());
            chk("R4 direction", {31'b0, mem_write}, {31'b0, m_dir});
            beats++;
            if (m_wbc != 0) m_wbc--;
            if (m_list && ((m_wac + 32'd1) & 32'h1000) != 0) begin
               m_wac = 0;
               m_wmac += 32'h1000;
            end else m_wac = m_wac + 32'd1;
            if (m_wbc == 0) m_done = 1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic check_work(string tag);
      logic [31:0] v;
      rd(3'd5, v); chk({tag, " wcnt"}, v, m_wbc);
      rd(3'd6, v); chk({tag, " waddr"}, v, m_wac);
      rd(3'd7, v); chk({tag, " wlist"}, v, m_wmac);
      rd(3'd4, v); chk({tag, " done"}, {31'b0, v[0]}, {31'b0, m_done});
   endtask

   task automatic do_start(bit lst, bit dir, logic [23:0] cnt, logic [31:0] sa, logic [31:0] sl);
      wr(3'd1, {8'b0, cnt});
      wr(3'd2, sa);
      wr(3'd3, sl);
      m_wac = sa; m_wmac = sl; m_wbc = (cnt == 0) ? 32'h0100_0000 : {8'b0, cnt};
      m_list = lst; m_dir = dir; m_done = 0;
      wr(3'd0, {28'b0, lst, dir, 2'b11});
   endtask

   task automatic burst(string tag, bit dir, logic [15:0] len);
      int exp, start_beats, t;
      exp = (dir != m_dir || m_wbc == 0) ? 0 : ((len < m_wbc) ? len : m_wbc);
      start_beats = beats;
      @(negedge clk);
      xfer_valid = 1'b1; xfer_dir = dir; xfer_len = len;
      #1;
      t = 0;
      while (!xfer_ready && t < 200) begin @(negedge clk); #1; t++; end
      @(negedge clk);
      xfer_valid = 1'b0;
      t = 0;
      while ((beats - start_beats) < exp && t < 400) begin @(negedge clk); t++; end
      repeat (4) @(negedge clk);
      chk({tag, " beat count"}, beats - start_beats, exp);
      check_work(tag);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20250101));
      m_wac = 0; m_wmac = 32'hFFFF_FFFC; m_wbc = 0; m_list = 0; m_dir = 0; m_done = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1 chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
      check_work("R1");
      rd(3'd4, v); chk("R1 status", v, 32'd0);

      // R2 zero start count loads 16M
      do_start(0, 1, 24'd0, 32'h0000_1230, 32'h0000_5000);
      check_work("R2 zero count");
      burst("R4 flat", 1, 16'd9);
      // R8 direction mismatch is dropped
      burst("R8 mismatch", 0, 16'd7);

      // R7 exhaust a short count, then keep asking
      do_start(0, 0, 24'd3, 32'h8000_0010, 32'h0);
      stall_on = 1;
      burst("R7 clamp", 0, 16'd10);
      burst("R7 after zero", 0, 16'd5);

      // R9 interrupt path with op start and count zero
      wr(3'd4, 32'h3);
      rd(3'd4, v); chk("R9 w1c done", v, 32'd0);
      @(negedge clk); scsi_irq = 1'b1;
      @(negedge clk);
      rd(3'd4, v); chk("R9 irq sets done and sint", v, 32'd3);
      @(negedge clk); scsi_irq = 1'b0;
      @(negedge clk);
      rd(3'd4, v); chk("R9 sint follows low", v, 32'd1);

      // R3 start clears status
      do_start(1, 1, 24'd20, 32'h0000_0FFC, 32'h0012_3000);
      rd(3'd4, v); chk("R3 status cleared", v, 32'd0);
      check_work("R2 list load");
      burst("R6 page wrap", 1, 16'd8);

      // R10 idle command freezes the engine
      wr(3'd0, 32'h0);
      m_done = 0;
      wr(3'd4, 32'h1);
      @(negedge clk); xfer_valid = 1'b1; xfer_dir = 1'b1; xfer_len = 16'd4;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1;
         chk("R10 xfer_ready low", {31'b0, xfer_ready}, 32'd0);
         chk("R10 mem_valid low", {31'b0, mem_valid}, 32'd0);
      end
      xfer_valid = 1'b0;
      check_work("R10 kept");
      @(negedge clk); scsi_irq = 1'b1;
      @(negedge clk);
      rd(3'd4, v); chk("R9 no done when idle", v, 32'd2);
      @(negedge clk); scsi_irq = 1'b0;
      @(negedge clk);

      // random mix
      for (int it = 0; it < 25; it++) begin
         bit lst, dir;
         logic [23:0] cnt;
         logic [31:0] sa;
         lst = $urandom % 2;
         dir = $urandom % 2;
         cnt = (($urandom % 8) == 0) ? 24'd0 : 24'(1 + $urandom % 50);
         sa  = lst ? (32'h0000_0FD0 + ($urandom % 48)) : $urandom;
         do_start(lst, dir, cnt, sa, $urandom);
         check_work("R2 random load");
         for (int b = 0; b < 3; b++) begin
            bit bd;
            bd = (($urandom % 5) == 0) ? !dir : dir;
            burst(lst ? "R5 random list" : "R4 random flat", bd, 16'($urandom % 40));
         end
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule